// File: doc/BRIEF.md
# Integrating Teleprinter Line Receiver

This block recovers five-bit teleprinter characters from an asynchronous serial line. It samples the line sixteen times per bit and decides each bit from all the samples in the bit slot rather than from one instant. A short noise burst inside a bit therefore does not change the result. The sample rate comes from a clock divider that is set by the baud configuration input.

Two timing modes are provided. In edge mode the receiver hunts for a mark-to-space edge, checks that the start bit is real, frames one character from that edge and then hunts again. A stop interval of exactly one bit is enough, and a longer interval of any length is accepted. In tracking mode the first character is acquired the same way. After that the bit slots run freely, and their phase is nudged by a filtered average of the timing error seen at every data transition. A burst of noise just before a start bit cannot pull the framing of the next character off its slots. A second decision mode replaces the majority vote with a single sample at mid-slot.

Top module: `tty_integ_rx`

## Requirements
- R1: The line idles at mark (1). A character is a space (0) start bit, five data bits with the first received bit in `char_o[0]`, and a mark stop bit. Every bit lasts 16 sample periods, and one sample period is `div_i`+1 clock cycles.
- R2: With `mid_mode_i`=0, a bit is decided mark only when more than half of the samples in its slot are mark. A tie decides space. A burst of opposite polarity up to 5 samples long inside a data bit leaves the character unchanged.
- R3: With `mid_mode_i`=1, each data bit takes the value of the single sample at slot index 8, where index 0 is the first sample of the slot. A burst that covers index 8 inverts that bit, and a burst that misses it has no effect.
- R4: With `track_en_i`=0, the receiver hunts for a new mark-to-space edge after every stop slot. A stop of exactly 16 samples followed at once by a start bit is received, and so is any longer stop.
- R5: A start edge is accepted only if at least 5 of the first 8 samples from the edge are space. Otherwise the receiver returns to hunting and delivers nothing, so space bursts of 3 or 4 samples on an idle line produce no character.
- R6: If the stop slot decides space, `frame_err_o` is 1 when `valid_o` pulses, and the character is still delivered. A mark stop gives `frame_err_o`=0.
- R7: `valid_o` is a pulse one clock wide, issued at the end of the stop slot. `char_o` and `frame_err_o` change only in a cycle where `valid_o` is high.
- R8: With `track_en_i`=1, once a character has been received the slots run freely. An idle slot that decides space starts the next character. A 6-sample space burst inside an idle slot neither delivers a character nor shifts the framing of the character that follows.
- R9: With `track_en_i`=1, each transition gives an error equal to its slot index, or that index minus 16 when the index is 8 or more. The errors feed avg += err − (avg>>>3). When avg reaches +8 the slot is stretched by one sample, and when it reaches −8 the slot is shortened by one sample. So a stream whose bits run 1/128 slow is received intact over 40 back-to-back characters. With `track_en_i`=0 no correction is made.
- R10: During reset `valid_o`, `frame_err_o` and `char_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Serial line level, 1 = mark |
| div_i | input | 16 | Clock cycles per sample period, minus one |
| track_en_i | input | 1 | 1 = transition-tracked free-running slots, 0 = per-character edge resync |
| mid_mode_i | input | 1 | 1 = single mid-slot sample decision, 0 = majority over the slot |
| char_o | output | 5 | Last received character, first bit in bit 0 |
| valid_o | output | 1 | One-cycle strobe when a character is delivered |
| frame_err_o | output | 1 | Stop slot of the delivered character was decided space |

## Verification
The assertions assume that `div_i` and both mode inputs are changed only while reset is held. They also assume that, in tracking mode, transmitter bit edges stay within a few samples of the receiver's slots, so the filtered error stays bounded. The stimulus changes the line only on whole sample periods and changes configuration only during reset. In tracking mode it keeps idle gaps and stops to whole bit slots and limits drift to one extra sample every eight bits. Noise bursts are placed inside data bits, or inside idle slots for the tracking case, so that the expected character follows directly from the slot rules.

// File: rtl/tty_rx_pkg.sv
package tty_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_FRAME  = 2'd1,
    ST_LOCKED = 2'd2
  } rx_state_e;
endpackage

// File: rtl/tty_rx_tick.sv
module tty_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // sample period is div_i+1 clocks
  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i != '0 && tick_o) |=> !tick_o);
endmodule

// File: rtl/tty_rx_integ.sv
module tty_rx_integ #(
  parameter int CNT_W = 6,
  parameter int IDX_W = 4,
  parameter int MID   = 8,
  parameter int OSR   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             acc_en_i,
  input  logic             dump_i,
  input  logic             sample_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] marks_o,
  output logic [CNT_W-1:0] total_o,
  output logic             mid_o
);
  logic [CNT_W-1:0] marks_q, total_q;

  // running sums include the sample of this tick
  assign marks_o = marks_q + CNT_W'(sample_i);
  assign total_o = total_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      marks_q <= '0;
      total_q <= '0;
      mid_o   <= 1'b1;
    end else if (tick_i && acc_en_i) begin
      if (dump_i) begin
        marks_q <= '0;
        total_q <= '0;
      end else begin
        marks_q <= marks_o;
        total_q <= total_o;
      end
      if (idx_i == IDX_W'(MID)) mid_o <= sample_i;
    end
  end

  p_total_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && acc_en_i) |-> (total_o <= CNT_W'(2*OSR)));
endmodule

// File: rtl/tty_rx_phase.sv
module tty_rx_phase #(
  parameter int OSR   = 16,
  parameter int IDX_W = 4,
  parameter int AVG_W = 8,
  parameter int SHIFT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic             edge_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             hold_o,
  output logic             skip_o
);
  localparam int LIM  = 1 << SHIFT;
  localparam int HALF = OSR / 2;

  logic signed [AVG_W-1:0] avg_q, err, avg_n;
  logic                    fire;

  always_comb begin
    err = $signed(AVG_W'(idx_i));
    if (idx_i >= IDX_W'(HALF)) err = err - $signed(AVG_W'(OSR));
    avg_n  = avg_q + err - (avg_q >>> SHIFT);
    fire   = tick_i && active_i && edge_i;
    hold_o = fire && (avg_n >= $signed(AVG_W'(LIM)));
    skip_o = fire && (avg_n <= -$signed(AVG_W'(LIM)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        avg_q <= '0;
    else if (!active_i) avg_q <= '0;
    else if (fire) begin
      if (hold_o)      avg_q <= avg_n - $signed(AVG_W'(LIM));
      else if (skip_o) avg_q <= avg_n + $signed(AVG_W'(LIM));
      else             avg_q <= avg_n;
    end
  end

  p_avg_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avg_q <= $signed(AVG_W'(LIM*HALF))) && (avg_q >= -$signed(AVG_W'(LIM*HALF))));
endmodule

// File: rtl/tty_integ_rx.sv
module tty_integ_rx
  import tty_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 5,
  parameter int DIV_W     = 16,
  parameter int AVG_W     = 8,
  parameter int SHIFT     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 track_en_i,
  input  logic                 mid_mode_i,
  output logic [DATA_BITS-1:0] char_o,
  output logic                 valid_o,
  output logic                 frame_err_o
);
  localparam int IDX_W    = $clog2(OSR);
  localparam int CNT_W    = IDX_W + 2;
  localparam int HALF     = OSR / 2;
  localparam int STOP_IDX = DATA_BITS + 1;
  localparam int BIT_W    = $clog2(STOP_IDX + 1);

  rx_state_e            state_q;
  logic                 sync1_q, sync2_q, prev_q;
  logic [IDX_W-1:0]     idx_q;
  logic [BIT_W-1:0]     bit_q;
  logic [DATA_BITS-1:0] data_q;
  logic                 tick, hold, skip, mid;
  logic [CNT_W-1:0]     marks, total;
  logic [CNT_W:0]       marks2;
  logic [1:0]           step;
  logic [IDX_W:0]       sum;
  logic                 in_hunt, track_act, acc_en, slot_end, decision;
  logic                 start_bad, quit_lock, dump, line_edge;

  tty_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick)
  );

  tty_rx_integ #(.CNT_W(CNT_W), .IDX_W(IDX_W), .MID(HALF), .OSR(OSR)) u_integ (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .acc_en_i(acc_en),
    .dump_i(dump), .sample_i(sync2_q), .idx_i(idx_q),
    .marks_o(marks), .total_o(total), .mid_o(mid)
  );

  tty_rx_phase #(.OSR(OSR), .IDX_W(IDX_W), .AVG_W(AVG_W), .SHIFT(SHIFT)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .active_i(track_act),
    .edge_i(line_edge), .idx_i(idx_q), .hold_o(hold), .skip_o(skip)
  );

  always_comb begin
    in_hunt   = (state_q == ST_HUNT);
    line_edge = (sync2_q != prev_q);
    track_act = track_en_i && !in_hunt;
    acc_en    = !in_hunt || !sync2_q;
    step      = hold ? 2'd0 : (skip ? 2'd2 : 2'd1);
    sum       = {1'b0, idx_q} + {{(IDX_W-1){1'b0}}, step};
    slot_end  = !in_hunt && sum[IDX_W];
    marks2    = {marks, 1'b0};
    decision  = mid_mode_i ? mid : (marks2 > {1'b0, total});
    // false-start filter: space must win the first half of the start bit
    start_bad = tick && (state_q == ST_FRAME) && (bit_q == '0) &&
                (idx_q == IDX_W'(HALF-1)) && (marks2 >= (CNT_W+1)'(HALF));
    quit_lock = tick && (state_q == ST_LOCKED) && !track_en_i;
    dump      = tick && (slot_end || start_bad || quit_lock);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HUNT;
      sync1_q     <= 1'b1;
      sync2_q     <= 1'b1;
      prev_q      <= 1'b1;
      idx_q       <= '0;
      bit_q       <= '0;
      data_q      <= '0;
      char_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
      valid_o <= 1'b0;
      if (tick) begin
        prev_q <= sync2_q;
        unique case (state_q)
          ST_HUNT: if (!sync2_q) begin
            state_q <= ST_FRAME;
            bit_q   <= '0;
            idx_q   <= IDX_W'(1);
          end
          ST_FRAME: if (start_bad) begin
            state_q <= ST_HUNT;
            idx_q   <= '0;
          end else begin
            idx_q <= sum[IDX_W-1:0];
            if (slot_end) begin
              if (bit_q == BIT_W'(STOP_IDX)) begin
                valid_o     <= 1'b1;
                char_o      <= data_q;
                frame_err_o <= !decision;
                bit_q       <= '0;
                state_q     <= track_en_i ? ST_LOCKED : ST_HUNT;
              end else begin
                if (bit_q != '0) data_q <= {decision, data_q[DATA_BITS-1:1]};
                bit_q <= bit_q + 1'b1;
              end
            end
          end
          ST_LOCKED: if (!track_en_i) begin
            state_q <= ST_HUNT;
            idx_q   <= '0;
          end else begin
            idx_q <= sum[IDX_W-1:0];
            if (slot_end && !decision) begin
              state_q <= ST_FRAME;
              bit_q   <= BIT_W'(1);
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_char_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(char_o));
  p_ferr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(frame_err_o));
  p_valid_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick));
  p_no_adj_edge_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !track_en_i |-> !(hold || skip));
endmodule

// File: tb/tty_integ_rx_bench.sv
module tty_integ_rx_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        line_i;
  logic [15:0] div_i;
  logic        track_en_i, mid_mode_i;
  logic [4:0]  char_o;
  logic        valid_o, frame_err_o;

  always #10 clk = ~clk;

  tty_integ_rx u_tty_integ_rx (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line_i), .div_i(div_i),
    .track_en_i(track_en_i), .mid_mode_i(mid_mode_i),
    .char_o(char_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  int errors = 0;
  int checks = 0;
  int div_cfg = 1;
  int drift_bc = 0;
  logic [4:0] exp_char [0:255];
  logic       exp_ferr [0:255];
  logic [4:0] got_char [0:255];
  logic       got_ferr [0:255];
  int n_exp = 0;
  int n_got = 0;
  int dbl_pulse = 0;
  logic prev_valid = 1'b0;

  always @(negedge clk) begin
    if (valid_o && n_got < 256) begin
      got_char[n_got] = char_o;
      got_ferr[n_got] = frame_err_o;
      n_got++;
    end
    if (valid_o && prev_valid) dbl_pulse++;
    prev_valid = valid_o;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic hold_line(logic v, int n);
    line_i = v;
    repeat (n * (div_cfg + 1)) @(negedge clk);
  endtask

  task automatic push_exp(logic [4:0] c, logic f);
    exp_char[n_exp] = c;
    exp_ferr[n_exp] = f;
    n_exp++;
  endtask

  // gb: data bit carrying a burst (-1 none), burst of glen samples at goff
  task automatic send_char(logic [4:0] c, int stop_n, logic stop_v,
                           int gb, int goff, int glen);
    hold_line(1'b0, 16);
    for (int i = 0; i < 5; i++) begin
      if (i == gb) begin
        hold_line(c[i], goff);
        hold_line(~c[i], glen);
        hold_line(c[i], 16 - goff - glen);
      end else begin
        hold_line(c[i], 16);
      end
    end
    if (!stop_v) hold_line(1'b0, 16);
    hold_line(1'b1, stop_n);
  endtask

  // slow transmitter: one extra sample every eight bits
  task automatic send_drift(logic [4:0] c);
    for (int i = 0; i < 7; i++) begin
      logic v;
      v = (i == 0) ? 1'b0 : ((i == 6) ? 1'b1 : c[i-1]);
      hold_line(v, (drift_bc % 8 == 7) ? 17 : 16);
      drift_bc++;
    end
  endtask

  task automatic do_reset(int d, logic trk, logic mid);
    rst_ni     = 1'b0;
    line_i     = 1'b1;
    div_cfg    = d;
    div_i      = 16'(d);
    track_en_i = trk;
    mid_mode_i = mid;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    n_got  = 0;
    n_exp  = 0;
    hold_line(1'b1, 20);
  endtask

  task automatic compare(string req);
    hold_line(1'b1, 48);
    check(n_got == n_exp, req, "character count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      check(got_char[i] == exp_char[i], req, "character", got_char[i], exp_char[i]);
      check(got_ferr[i] == exp_ferr[i], req, "frame error", got_ferr[i], exp_ferr[i]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [4:0] c;
    int gb, goff;
    void'($urandom(32'h1F2E3D4C));
    rst_ni = 1'b0; line_i = 1'b1; div_i = 16'd1;
    track_en_i = 1'b0; mid_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    // R10 outputs held low in reset
    check(valid_o == 1'b0, "R10", "valid in reset", valid_o, 0);
    check(frame_err_o == 1'b0, "R10", "frame error in reset", frame_err_o, 0);
    check(char_o == 5'd0, "R10", "char in reset", char_o, 0);

    // R1 R4 edge mode, 1.0 stop and random longer stops, div 3
    do_reset(3, 1'b0, 1'b0);
    send_char(5'h15, 16, 1'b1, -1, 0, 0); push_exp(5'h15, 1'b0);
    send_char(5'h0A, 16, 1'b1, -1, 0, 0); push_exp(5'h0A, 1'b0);
    send_char(5'h1F, 24, 1'b1, -1, 0, 0); push_exp(5'h1F, 1'b0);
    send_char(5'h00, 16, 1'b1, -1, 0, 0); push_exp(5'h00, 1'b0);
    for (int k = 0; k < 20; k++) begin
      c = 5'($urandom_range(0, 31));
      send_char(c, 16 + $urandom_range(0, 24), 1'b1, -1, 0, 0);
      push_exp(c, 1'b0);
    end
    compare("R4");
    // R7 char held after last strobe, strobe one cycle wide
    check(char_o == exp_char[n_exp-1], "R7", "char held", char_o, exp_char[n_exp-1]);

    // R2 majority decision survives 5-sample bursts anywhere in a bit
    do_reset(1, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) begin
      c    = 5'($urandom_range(0, 31));
      gb   = $urandom_range(0, 4);
      goff = $urandom_range(0, 11);
      send_char(c, 16 + $urandom_range(0, 8), 1'b1, gb, goff, 5);
      push_exp(c, 1'b0);
    end
    compare("R2");

    // R3 mid-slot decision: burst covering index 8 inverts the bit
    do_reset(1, 1'b0, 1'b1);
    for (int k = 0; k < 12; k++) begin
      c    = 5'($urandom_range(0, 31));
      gb   = $urandom_range(0, 4);
      goff = (k < 2) ? ((k == 0) ? 4 : 3) : $urandom_range(0, 11);
      send_char(c, 16 + $urandom_range(0, 8), 1'b1, gb, goff, 5);
      push_exp((goff >= 4 && goff <= 8) ? (c ^ (5'd1 << gb)) : c, 1'b0);
    end
    compare("R3");

    // R5 short space bursts rejected as false starts
    do_reset(1, 1'b0, 1'b0);
    hold_line(1'b0, 3); hold_line(1'b1, 20);
    hold_line(1'b0, 4); hold_line(1'b1, 20);
    check(n_got == 0, "R5", "strobes after false starts", n_got, 0);
    send_char(5'h13, 16, 1'b1, -1, 0, 0); push_exp(5'h13, 1'b0);
    compare("R5");

    // R6 space stop flags framing error, char still delivered
    do_reset(1, 1'b0, 1'b0);
    send_char(5'h19, 16, 1'b0, -1, 0, 0); push_exp(5'h19, 1'b1);
    send_char(5'h06, 16, 1'b1, -1, 0, 0); push_exp(5'h06, 1'b0);
    send_char(5'h0E, 20, 1'b0, -1, 0, 0); push_exp(5'h0E, 1'b1);
    compare("R6");

    // R8 tracking: burst in an idle slot does not disturb framing
    do_reset(1, 1'b1, 1'b0);
    send_char(5'h0B, 16, 1'b1, -1, 0, 0); push_exp(5'h0B, 1'b0);
    hold_line(1'b1, 32);
    hold_line(1'b1, 6); hold_line(1'b0, 6); hold_line(1'b1, 4);
    check(n_got == 1, "R8", "strobes after idle burst", n_got, 1);
    send_char(5'h14, 16, 1'b1, -1, 0, 0); push_exp(5'h14, 1'b0);
    for (int k = 0; k < 10; k++) begin
      c = 5'($urandom_range(0, 31));
      send_char(c, 16 * (1 + $urandom_range(0, 2)), 1'b1, -1, 0, 0);
      push_exp(c, 1'b0);
    end
    compare("R8");

    // R9 tracking holds phase on a slow back-to-back stream
    do_reset(1, 1'b1, 1'b0);
    send_char(5'h15, 16, 1'b1, -1, 0, 0); push_exp(5'h15, 1'b0);
    drift_bc = 0;
    for (int k = 0; k < 40; k++) begin
      c = 5'($urandom_range(1, 30));
      send_drift(c);
      push_exp(c, 1'b0);
    end
    compare("R9");

    // R7 no strobe ever longer than one cycle
    check(dbl_pulse == 0, "R7", "wide strobes", dbl_pulse, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule